// File: doc/BRIEF.md
# Serial Slave Pause Controller

This block sits in the front end of a serial memory slave and gives it a pause state. The host can drive an active-low pause pin to stop a transfer partway through. The pause takes effect only while chip select is asserted. While paused, the slave's shift engine is frozen. Activity on the serial clock and data input is disregarded, and the data output driver is released. The bit position and the partly assembled byte are kept, so the transfer carries on at the same bit once the pause ends.

Entering and leaving the pause is always aligned to a low phase of the serial clock. A pin edge that arrives while the clock is high takes effect only once the clock is seen low. If chip select is released during a pause, the slave's sequence state is reset and a one-cycle abort pulse is raised. The pause cannot then resume on the next selection until the pause pin has been seen high. An internal long-running cycle, such as a program, erase or status write, keeps counting whether or not a pause is active.

All pins are sampled by a fast system clock through synchroniser chains. Edges of the serial clock are detected in the system clock domain. Command decoding is not part of this block.

Top module: `spi_pause_ctrl`

## Requirements
- R1: The pause state is never entered while the synchronised chip select (`cs_n`) is high.
- R2: When `cs_n` is low and `hold_n` is low, the pause starts as soon as `sck` is seen low. If `sck` is high when `hold_n` falls, `hold_active` stays 0 until `sck` next goes low.
- R3: When `hold_n` returns high, the pause ends as soon as `sck` is seen low. If `sck` is high at that point, `hold_active` stays 1 until `sck` next goes low.
- R4: `miso_oe` is 1 only while selected and not paused. It is 0 while paused and 0 while deselected.
- R5: While paused, edges on `sck` and values on `mosi` have no effect. `bit_pos` and the partial byte are kept, and the byte completes correctly after the pause ends.
- R6: A `cyc_start` pulse while idle holds `busy` high for exactly `CYC_LEN` system clock cycles, whatever happens on `hold_n`.
- R7: A rising `cs_n` during a pause produces a one-cycle `hold_abort` pulse, clears `hold_active` and returns `bit_pos` to 0.
- R8: After an abort, a new selection with `hold_n` still low does not pause. The pause is possible again only after `hold_n` has been seen high.
- R9: `miso` is updated on each falling `sck` edge to `tx_byte[WORD_W-1-bit_pos]`, so bits go out MSB first. While deselected, `miso` shows `tx_byte[WORD_W-1]`.
- R10: Input bits are captured MSB first on rising `sck` edges. After `WORD_W` rising edges, `rx_byte` holds the word and `rx_valid` pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select pin, active low |
| sck | input | 1 | Serial clock pin |
| mosi | input | 1 | Serial data input pin |
| hold_n | input | 1 | Pause request pin, active low |
| tx_byte | input | WORD_W | Word to shift out |
| cyc_start | input | 1 | Starts an internal long cycle |
| miso | output | 1 | Serial data output value |
| miso_oe | output | 1 | Output driver enable |
| rx_byte | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle pulse when a word completes |
| bit_pos | output | $clog2(WORD_W) | Current bit position in the word |
| hold_active | output | 1 | Pause state |
| hold_abort | output | 1 | Pulse when chip select rises during a pause |
| busy | output | 1 | Internal cycle in progress |

## Verification
The bench builds the block with `WORD_W=8`, `SYNC_STAGES=2` and `CYC_LEN=40`. With 8-bit words, a paused word can be stopped after its third bit and rebuilt from known bits on either side of the pause. A 40-cycle internal cycle is long enough that both a pause entry and a pause exit fall inside it. Each serial clock half period lasts eight system clocks. This leaves room to place pin edges while the serial clock is high and so check the deferred entry and deferred exit paths.

// File: rtl/spi_pause_pkg.sv
// Shared types for the serial pause controller.
// Assumes all pin samples are taken in the system clock domain.
package spi_pause_pkg;
    // Synchronised view of the serial pins
    typedef struct packed {
        logic cs_n;
        logic sck;
        logic hold_n;
        logic mosi;
    } pins_t;

    localparam int PIN_COUNT = 4;
endpackage

// File: rtl/pin_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
// Each bit gets its own chain with a per-bit reset value.
module pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic [STAGES-1:0] chain;
            // shift the pin value through the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL[gi]}};
                else        chain <= {chain[STAGES-2:0], d[gi]};
            end
            assign q[gi] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pause_fsm.sv
// Pause state tracker: entry and exit are qualified on the serial clock
// being low; a deselect during a pause aborts and locks out re-entry
// until the pause pin has been seen high. Inputs are already synchronised.
module pause_fsm
    import spi_pause_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pins,
    output logic  hold_q,
    output logic  abort_q
);
    logic lockout;

    // pause state, gated by chip select and serial clock low phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (pins.cs_n) begin
            hold_q <= 1'b0;
        end else if (!hold_q) begin
            if (!pins.hold_n && !pins.sck && !lockout) hold_q <= 1'b1;
        end else if (pins.hold_n && !pins.sck) begin
            hold_q <= 1'b0;
        end
    end

    // lockout after a deselect-abort, cleared by the pin going high
    always_ff @(posedge clk) begin
        if (!rst_n)                    lockout <= 1'b0;
        else if (hold_q && pins.cs_n)  lockout <= 1'b1;
        else if (pins.hold_n)          lockout <= 1'b0;
    end

    // one-cycle abort pulse
    always_ff @(posedge clk) begin
        if (!rst_n) abort_q <= 1'b0;
        else        abort_q <= hold_q & pins.cs_n;
    end

    assert_entry_selected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_q) |-> !$past(pins.cs_n));
    assert_entry_sck_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_q) |-> !$past(pins.sck));
    assert_exit_sck_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_q) && !$past(pins.cs_n)) |-> !$past(pins.sck));
    assert_no_reentry_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_q) |-> !$past(lockout));
endmodule

// File: rtl/shift_core.sv
// Serial shift engine: captures input on rising serial clock edges and
// updates the output bit on falling edges. A freeze input stops all
// progress while keeping the bit position and partial word.
module shift_core
    import spi_pause_pkg::*;
#(
    parameter int WORD_W = 8,
    localparam int CW = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pins_t             pins,
    input  logic              freeze,
    input  logic [WORD_W-1:0] tx_byte,
    output logic [CW-1:0]     bit_cnt,
    output logic [WORD_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              sdo
);
    logic              sck_d;
    logic [WORD_W-1:0] shreg;
    logic              rise, fall;
    logic [CW-1:0]     out_idx;

    assign rise    = pins.sck & ~sck_d;
    assign fall    = ~pins.sck & sck_d;
    assign out_idx = CW'(WORD_W - 1) - bit_cnt;

    // previous serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= pins.sck;
    end

    // bit counter, input shift and output bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            sdo      <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (pins.cs_n) begin
                bit_cnt <= '0;
                sdo     <= tx_byte[WORD_W-1];
            end else if (!freeze) begin
                if (rise) begin
                    shreg <= {shreg[WORD_W-2:0], pins.mosi};
                    if (bit_cnt == CW'(WORD_W - 1)) begin
                        rx_byte  <= {shreg[WORD_W-2:0], pins.mosi};
                        rx_valid <= 1'b1;
                        bit_cnt  <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (fall) sdo <= tx_byte[out_idx];
            end
        end
    end

    assert_frozen_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !pins.cs_n) |=> $stable(bit_cnt));
    assert_frozen_no_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !pins.cs_n) |=> !rx_valid);
endmodule

// File: rtl/cycle_timer.sv
// Internal long-cycle timer: runs for a fixed number of system clocks
// once started and takes no input from the pause logic.
module cycle_timer #(
    parameter int CYC_LEN = 16,
    localparam int TW = $clog2(CYC_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [TW-1:0] remain;

    // countdown while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                remain <= TW'(CYC_LEN - 1);
            end
        end else if (remain == '0) begin
            busy <= 1'b0;
        end else begin
            remain <= remain - 1'b1;
        end
    end

    assert_start_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: rtl/spi_pause_ctrl.sv
// Top level of the serial slave pause controller. Synchronises the pins,
// tracks the pause state, freezes the shift engine while paused and
// releases the output driver. The internal cycle timer runs independently.
module spi_pause_ctrl
    import spi_pause_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CYC_LEN     = 16,
    localparam int CW = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              hold_n,
    input  logic [WORD_W-1:0] tx_byte,
    input  logic              cyc_start,
    output logic              miso,
    output logic              miso_oe,
    output logic [WORD_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic [CW-1:0]     bit_pos,
    output logic              hold_active,
    output logic              hold_abort,
    output logic              busy
);
    pins_t pins;
    logic  hold_q;

    pin_sync #(
        .WIDTH  (PIN_COUNT),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs_n, sck, hold_n, mosi}),
        .q    (pins)
    );

    pause_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins   (pins),
        .hold_q (hold_q),
        .abort_q(hold_abort)
    );

    shift_core #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins    (pins),
        .freeze  (hold_q),
        .tx_byte (tx_byte),
        .bit_cnt (bit_pos),
        .rx_byte (rx_byte),
        .rx_valid(rx_valid),
        .sdo     (miso)
    );

    cycle_timer #(.CYC_LEN(CYC_LEN)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(cyc_start),
        .busy (busy)
    );

    assign hold_active = hold_q;
    assign miso_oe     = ~pins.cs_n & ~hold_q;

    assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_abort |-> (!hold_active && bit_pos == '0));
endmodule

// File: tb/sim_spi_pause_ctrl.sv
module sim_spi_pause_ctrl;
    localparam int W = 8;
    localparam int CL = 40;
    localparam int H = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, cyc_start = 1'b0;
    logic [W-1:0] tx_byte = 8'hB2;
    logic miso, miso_oe, rx_valid, hold_active, hold_abort, busy;
    logic [W-1:0] rx_byte;
    logic [2:0] bit_pos;

    int checks = 0, errors = 0, aborts = 0;
    bit done = 0;
    logic [W-1:0] exp_q[$];

    always #4 clk = ~clk;

    spi_pause_ctrl #(.WORD_W(W), .SYNC_STAGES(2), .CYC_LEN(CL)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .hold_n(hold_n), .tx_byte(tx_byte), .cyc_start(cyc_start),
        .miso(miso), .miso_oe(miso_oe), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .bit_pos(bit_pos), .hold_active(hold_active), .hold_abort(hold_abort),
        .busy(busy));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        mosi = b; wt(H); sck = 1'b1; wt(H); sck = 1'b0;
    endtask

    // monitor: compare completed words against the scoreboard (R10)
    always @(negedge clk) begin
        if (hold_abort) aborts++;
        if (rx_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 actual=%0h expected=none", rx_byte);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                if (rx_byte != e) begin
                    errors++;
                    $display("FAIL R10 actual=%0h expected=%0h", rx_byte, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int busy_n, hold_mid;
        wt(4); rst_n = 1'b1; wt(4);
        // reset state
        chk("R4 reset oe", miso_oe, 0);
        chk("R7 reset hold", hold_active, 0);
        chk("R9 deselected msb", miso, 1);
        chk("R6 reset busy", busy, 0);

        // plain word
        cs_n = 1'b0; wt(H);
        chk("R4 oe selected", miso_oe, 1);
        exp_q.push_back(8'hA5);
        for (int i = W - 1; i >= 0; i--) send_bit(8'hA5 >> i);
        wt(H);
        cs_n = 1'b1; wt(H);

        // paused word: bits 101, pause, then 10011 -> B3
        exp_q.push_back(8'hB3);
        cs_n = 1'b0; wt(H);
        send_bit(1'b1); wt(H);
        chk("R9 miso after bit1", miso, 0);
        send_bit(1'b0); send_bit(1'b1); wt(H);
        chk("R9 miso after bit3", miso, 1);
        hold_n = 1'b0; wt(6);
        chk("R2 immediate entry", hold_active, 1);
        chk("R4 oe off in pause", miso_oe, 0);
        for (int k = 0; k < 3; k++) begin
            mosi = ~mosi; sck = 1'b1; wt(H); sck = 1'b0; wt(H);
        end
        sck = 1'b1; wt(H);
        chk("R5 count frozen", bit_pos, 3);
        hold_n = 1'b1; wt(6);
        chk("R3 deferred exit", hold_active, 1);
        sck = 1'b0; wt(6);
        chk("R3 exit on low", hold_active, 0);
        chk("R5 count kept", bit_pos, 3);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        send_bit(1'b1); send_bit(1'b1); wt(H);
        cs_n = 1'b1; wt(H);

        // deferred entry
        cs_n = 1'b0; sck = 1'b1; wt(H);
        hold_n = 1'b0; wt(6);
        chk("R2 deferred entry", hold_active, 0);
        sck = 1'b0; wt(6);
        chk("R2 entry on low", hold_active, 1);
        hold_n = 1'b1; wt(6);
        chk("R3 immediate exit", hold_active, 0);
        cs_n = 1'b1; wt(H);

        // deselected: no pause
        hold_n = 1'b0; wt(6);
        chk("R1 no pause deselected", hold_active, 0);
        hold_n = 1'b1; wt(6);

        // abort during pause, then lockout
        cs_n = 1'b0; wt(H);
        send_bit(1'b1); send_bit(1'b1); wt(H);
        hold_n = 1'b0; wt(6);
        chk("R7 paused", hold_active, 1);
        aborts = 0;
        cs_n = 1'b1; wt(6);
        chk("R7 abort pulse count", aborts, 1);
        chk("R7 hold cleared", hold_active, 0);
        chk("R7 bit_pos reset", bit_pos, 0);
        cs_n = 1'b0; wt(H);
        chk("R8 lockout", hold_active, 0);
        chk("R8 oe while locked", miso_oe, 1);
        hold_n = 1'b1; wt(6);
        hold_n = 1'b0; wt(6);
        chk("R8 re-entry after release", hold_active, 1);
        hold_n = 1'b1; wt(6);
        cs_n = 1'b1; wt(H);

        // internal cycle across a pause
        cs_n = 1'b0; wt(H);
        cyc_start = 1'b1; wt(1); cyc_start = 1'b0;
        busy_n = 0; hold_mid = 0;
        for (int i = 0; i < 70; i++) begin
            if (i == 5) hold_n = 1'b0;
            if (i == 15) hold_mid = hold_active;
            if (i == 22) hold_n = 1'b1;
            if (busy) busy_n++;
            wt(1);
        end
        chk("R6 pause inside cycle", hold_mid, 1);
        chk("R6 busy length", busy_n, CL);
        cs_n = 1'b1; wt(H);

        chk("R10 all words seen", exp_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule